// File: doc/BRIEF.md
# Prescaled Multi-Channel System Timer

This block is a memory-mapped system timer for a large chip. A 32-bit up counter advances once every N system clocks. N comes from an 8-bit prescale field and runs from 1 to 256. Four compare channels watch the counter. Each channel sets a sticky flag, and drives its own interrupt line, when it is enabled and the counter equals its compare value.

Software reaches the timer over a simple single-request, single-response 32-bit register bus. A control word holds the run enable, a freeze bit and the prescale field. The counter word can be read and loaded. Each channel has an enable word, a flag word and a compare word. Only full-word accesses from supervisor mode to a decoded offset are accepted; every other access gets an error response and changes nothing. A debug-mode input halts counting, but only while the freeze bit is set.

Top module: `pst_timer`

## Requirements
- R1: After reset the counter, control word, all channel enables, compare values and flags are zero, irq is zero, and bus_ack and bus_err are low.
- R2: With the run enable set and no freeze, a prescale field of k makes the counter step by exactly one every k+1 clocks, so 0 steps every clock and 0xFF every 256 clocks; the counter wraps from 0xFFFFFFFF to 0.
- R3: While the run enable (control bit 0) is clear, the counter and its prescale phase hold their values.
- R4: While dbg_mode is high and the freeze bit (control bit 1) is set, the counter holds; with the freeze bit clear, dbg_mode has no effect.
- R5: Offset 0x04 reads the counter; a write there loads the counter and takes priority over a step in the same cycle.
- R6: Offset 0x00 is the control word: bit 0 run enable, bit 1 freeze, bits 15:8 prescale; all other bits read as zero.
- R7: Channel n uses offset 0x10+0x10·n for its enable (bit 0), 0x14+0x10·n for its flag (bit 0) and 0x18+0x10·n for its 32-bit compare value; unused bits read as zero.
- R8: A channel whose enable is set sets its flag at the clock edge where the counter equals its compare value; irq[n] is high exactly while flag n is set.
- R9: Writing 1 to a flag's bit 0 clears it and writing 0 leaves it unchanged; if the match holds in the same cycle, the flag stays set.
- R10: An access whose bus_size is not 2'b10 (word) gets an error response and writes nothing.
- R11: An access to a misaligned offset, to 0x08, 0x0C, the fourth word of a channel slot, or any offset above the last channel gets an error response and writes nothing.
- R12: An access with bus_super low gets an error response and writes nothing.
- R13: Each cycle with bus_req high is answered in the next cycle by exactly one of bus_ack or bus_err; bus_rdata carries the read data with bus_ack and is zero otherwise; no response appears without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_mode | input | 1 | Device is in debug mode |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_size | input | 2 | Access size, 2'b10 is a word |
| bus_super | input | 1 | Requester is in supervisor mode |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| bus_ack | output | 1 | Access accepted, one cycle after the request |
| bus_err | output | 1 | Access rejected, one cycle after the request |
| irq | output | 4 | One interrupt line per compare channel |

## Verification
A wrong flag or channel enable reaches irq at the next clock edge, so a per-cycle comparison against a behavioural model sees it within one cycle. A wrong counter value or prescale phase stays hidden until the counter is read, or until a compare match fires too early or too late. The bench therefore reads the counter after every timing mode and places compare values so that a phase error of one step moves an interrupt edge. A write that should have been rejected shows only when the register it would have hit is read back, so every error case is followed by such a read.

// File: rtl/pst_pkg.sv
package pst_pkg;

  localparam int DW    = 32;
  localparam int AW    = 8;
  localparam int PSC_W = 8;

  localparam logic [1:0] SZ_WORD = 2'b10;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_CTRL,
    RK_CNT,
    RK_CHEN,
    RK_FLAG,
    RK_CMP
  } reg_kind_e;

  typedef struct packed {
    logic [PSC_W-1:0] psc;
    logic             frz;
    logic             en;
  } ctrl_t;

  // Classify a byte offset; nch is the number of channel slots present.
  function automatic reg_kind_e f_decode(input logic [AW-1:0] a, input int nch);
    reg_kind_e k;
    int        slot;
    k    = RK_NONE;
    slot = int'(a[AW-1:4]);
    if (a[1:0] == 2'b00) begin
      if (slot == 0) begin
        if (a[3:2] == 2'd0)      k = RK_CTRL;
        else if (a[3:2] == 2'd1) k = RK_CNT;
      end else if (slot <= nch) begin
        case (a[3:2])
          2'd0:    k = RK_CHEN;
          2'd1:    k = RK_FLAG;
          2'd2:    k = RK_CMP;
          default: k = RK_NONE;
        endcase
      end
    end
    return k;
  endfunction

  // Channel number of a channel-slot offset.
  function automatic int f_chan(input logic [AW-1:0] a);
    return int'(a[AW-1:4]) - 1;
  endfunction

  function automatic logic [DW-1:0] f_ctrl_word(input ctrl_t c);
    return {16'b0, c.psc, 6'b0, c.frz, c.en};
  endfunction

  function automatic ctrl_t f_ctrl_from(input logic [DW-1:0] w);
    ctrl_t c;
    c.en  = w[0];
    c.frz = w[1];
    c.psc = w[15:8];
    return c;
  endfunction

  // A step is due once the phase has reached the prescale field.
  function automatic logic f_step_due(input logic [PSC_W-1:0] phase,
                                      input logic [PSC_W-1:0] psc);
    return phase >= psc;
  endfunction

endpackage

// File: rtl/pst_tick_gen.sv
module pst_tick_gen
  import pst_pkg::*;
#(
  parameter int PW = PSC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [PW-1:0] psc,
  output logic          tick
);

  logic [PW-1:0] phase_q;

  assign tick = run && f_step_due(phase_q, psc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (run) begin
      phase_q <= tick ? '0 : phase_q + 1'b1;
    end
  end

endmodule

// File: rtl/pst_counter.sv
module pst_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (inc) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/pst_channel.sv
module pst_channel #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt,
  input  logic         en_we,
  input  logic         en_d,
  input  logic         cmp_we,
  input  logic [W-1:0] cmp_d,
  input  logic         clr,
  output logic         en_q,
  output logic [W-1:0] cmp_q,
  output logic         flag_q,
  output logic         match
);

  assign match = en_q && (cnt == cmp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      cmp_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (en_we)  en_q  <= en_d;
      if (cmp_we) cmp_q <= cmp_d;
      if (match)    flag_q <= 1'b1;
      else if (clr) flag_q <= 1'b0;
    end
  end

endmodule

// File: rtl/pst_timer.sv
module pst_timer
  import pst_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           dbg_mode,
  input  logic           bus_req,
  input  logic           bus_wr,
  input  logic [AW-1:0]  bus_addr,
  input  logic [1:0]     bus_size,
  input  logic           bus_super,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  output logic           bus_ack,
  output logic           bus_err,
  output logic [NCH-1:0] irq
);

  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

  reg_kind_e      sel;
  logic [CHW-1:0] ch_idx;
  logic           acc_ok, wr_ok, ctrl_wr, cnt_wr;
  logic           run, tick, ctrl_en, ctrl_frz;
  ctrl_t          ctrl_q;
  logic [DW-1:0]  cnt_q, rd_mux;
  logic [NCH-1:0] ch_en, ch_flag, match_evt, flag_clr;
  logic [DW-1:0]  ch_cmp [NCH];

  // Access qualification
  assign sel     = f_decode(bus_addr, NCH);
  assign ch_idx  = CHW'(f_chan(bus_addr));
  assign acc_ok  = bus_req && bus_super && (bus_size == SZ_WORD) && (sel != RK_NONE);
  assign wr_ok   = acc_ok && bus_wr;
  assign ctrl_wr = wr_ok && (sel == RK_CTRL);
  assign cnt_wr  = wr_ok && (sel == RK_CNT);

  // Control word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= f_ctrl_from(bus_wdata);
  end

  assign ctrl_en  = ctrl_q.en;
  assign ctrl_frz = ctrl_q.frz;
  assign run      = ctrl_en && !(dbg_mode && ctrl_frz);

  pst_tick_gen #(.PW(PSC_W)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .psc   (ctrl_q.psc),
    .tick  (tick)
  );

  pst_counter #(.W(DW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc      (tick),
    .load     (cnt_wr),
    .load_val (bus_wdata),
    .cnt_q    (cnt_q)
  );

  // Compare channels
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic hit_g;
    assign hit_g       = wr_ok && (ch_idx == CHW'(g));
    assign flag_clr[g] = hit_g && (sel == RK_FLAG) && bus_wdata[0];

    pst_channel #(.W(DW)) u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .cnt    (cnt_q),
      .en_we  (hit_g && (sel == RK_CHEN)),
      .en_d   (bus_wdata[0]),
      .cmp_we (hit_g && (sel == RK_CMP)),
      .cmp_d  (bus_wdata),
      .clr    (flag_clr[g]),
      .en_q   (ch_en[g]),
      .cmp_q  (ch_cmp[g]),
      .flag_q (ch_flag[g]),
      .match  (match_evt[g])
    );
  end

  assign irq = ch_flag;

  // Read multiplexer
  always_comb begin
    case (sel)
      RK_CTRL: rd_mux = f_ctrl_word(ctrl_q);
      RK_CNT:  rd_mux = cnt_q;
      RK_CHEN: rd_mux = DW'(ch_en[ch_idx]);
      RK_FLAG: rd_mux = DW'(ch_flag[ch_idx]);
      RK_CMP:  rd_mux = ch_cmp[ch_idx];
      default: rd_mux = '0;
    endcase
  end

  // Registered response
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_ack   <= 1'b0;
      bus_err   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ack   <= acc_ok;
      bus_err   <= bus_req && !acc_ok;
      bus_rdata <= (acc_ok && !bus_wr) ? rd_mux : '0;
    end
  end

endmodule

// File: rtl/pst_timer_chk.sv
module pst_timer_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           dbg_mode,
  input logic           bus_req,
  input logic           bus_ack,
  input logic           bus_err,
  input logic [NCH-1:0] irq,
  input logic           run,
  input logic           tick,
  input logic           cnt_wr,
  input logic           ctrl_en,
  input logic           ctrl_frz,
  input logic [31:0]    cnt_q,
  input logic [NCH-1:0] match_evt,
  input logic [NCH-1:0] flag_clr
);

  p_one_resp_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_ack && bus_err));

  p_resp_next_r13: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |=> (bus_ack || bus_err));

  p_no_spurious_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |=> !(bus_ack || bus_err));

  p_idle_no_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !tick);

  p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr) |=> (cnt_q == $past(cnt_q) + 32'd1));

  p_hold_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_en && !cnt_wr) |=> $stable(cnt_q));

  p_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_mode && ctrl_frz && !cnt_wr) |=> $stable(cnt_q));

  p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt != '0) |=> ((irq & $past(match_evt)) == $past(match_evt)));

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq != '0) |=> ((($past(irq) & ~$past(flag_clr)) & ~irq) == '0));

endmodule

bind pst_timer pst_timer_chk #(.NCH(NCH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dbg_mode  (dbg_mode),
  .bus_req   (bus_req),
  .bus_ack   (bus_ack),
  .bus_err   (bus_err),
  .irq       (irq),
  .run       (run),
  .tick      (tick),
  .cnt_wr    (cnt_wr),
  .ctrl_en   (ctrl_en),
  .ctrl_frz  (ctrl_frz),
  .cnt_q     (cnt_q),
  .match_evt (match_evt),
  .flag_clr  (flag_clr)
);

// File: tb/tb_pst_timer.sv
`timescale 1ns/1ps
module tb_pst_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dbg_mode = 1'b0;
  logic        bus_req = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [1:0]  bus_size = 2'b10;
  logic        bus_super = 1'b1;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ack, bus_err;
  logic [3:0]  irq;

  always #4 clk = ~clk;

  pst_timer #(.NCH(4)) dut (
    .clk(clk), .rst_n(rst_n), .dbg_mode(dbg_mode),
    .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_super(bus_super), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack), .bus_err(bus_err), .irq(irq)
  );

  // Behavioural reference model
  logic [31:0] m_cnt = '0;
  int          m_pc = 0;
  logic        m_en = 0, m_frz = 0;
  logic [7:0]  m_psc = '0;
  logic [3:0]  m_chen = '0, m_flag = '0;
  logic [31:0] m_cmp [4] = '{default: '0};
  logic        m_ack = 0, m_err = 0;
  logic [31:0] m_rd = '0;

  int    checks = 0, fails = 0, cyc = 0;
  string tag = "R1";

  function automatic bit m_legal(input logic [7:0] a);
    if (a == 8'h00 || a == 8'h04) return 1;
    for (int c = 0; c < 4; c++)
      if (a == 8'(16 + 16*c) || a == 8'(20 + 16*c) || a == 8'(24 + 16*c)) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] m_read(input logic [7:0] a);
    if (a == 8'h00) return {16'h0, m_psc, 6'h0, m_frz, m_en};
    if (a == 8'h04) return m_cnt;
    for (int c = 0; c < 4; c++) begin
      if (a == 8'(16 + 16*c)) return {31'h0, m_chen[c]};
      if (a == 8'(20 + 16*c)) return {31'h0, m_flag[c]};
      if (a == 8'(24 + 16*c)) return m_cmp[c];
    end
    return '0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = '0; m_pc = 0; m_en = 0; m_frz = 0; m_psc = '0;
      m_chen = '0; m_flag = '0; m_ack = 0; m_err = 0; m_rd = '0;
      for (int c = 0; c < 4; c++) m_cmp[c] = '0;
    end else begin
      bit          ok, stepped;
      logic [3:0]  nflag;
      logic [31:0] ncnt;
      ok    = bus_req && bus_super && bus_size == 2'b10 && m_legal(bus_addr);
      m_rd  = (ok && !bus_wr) ? m_read(bus_addr) : '0;
      m_ack = ok;
      m_err = bus_req && !ok;
      for (int c = 0; c < 4; c++) begin
        bit clr;
        clr = ok && bus_wr && bus_addr == 8'(20 + 16*c) && bus_wdata[0];
        nflag[c] = (m_chen[c] && m_cnt == m_cmp[c]) || (m_flag[c] && !clr);
      end
      stepped = 0;
      if (m_en && !(dbg_mode && m_frz)) begin
        m_pc++;
        if (m_pc > int'(m_psc)) begin m_pc = 0; stepped = 1; end
      end
      ncnt = stepped ? m_cnt + 1 : m_cnt;
      if (ok && bus_wr) begin
        if (bus_addr == 8'h00) begin
          m_en = bus_wdata[0]; m_frz = bus_wdata[1]; m_psc = bus_wdata[15:8];
        end
        if (bus_addr == 8'h04) ncnt = bus_wdata;
        for (int c = 0; c < 4; c++) begin
          if (bus_addr == 8'(16 + 16*c)) m_chen[c] = bus_wdata[0];
          if (bus_addr == 8'(24 + 16*c)) m_cmp[c] = bus_wdata;
        end
      end
      m_flag = nflag;
      m_cnt  = ncnt;
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    cyc++;
    checks++;
    if (bus_ack !== m_ack || bus_err !== m_err || bus_rdata !== m_rd || irq !== m_flag) begin
      fails++;
      $display("FAIL %s t=%0t: actual ack=%b err=%b rdata=%h irq=%b expected ack=%b err=%b rdata=%h irq=%b",
               tag, $time, bus_ack, bus_err, bus_rdata, irq, m_ack, m_err, m_rd, m_flag);
    end
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog: actual cycles=%0d expected below 20000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic acc(input logic wr, input logic [7:0] a, input logic [31:0] wd,
                     input logic [1:0] sz = 2'b10, input logic sup = 1'b1);
    bus_req = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    bus_size = sz; bus_super = sup;
    @(negedge clk);
    bus_req = 1'b0; bus_wr = 1'b0; bus_size = 2'b10; bus_super = 1'b1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] wd);
    acc(1'b1, a, wd);
  endtask

  task automatic rd(input logic [7:0] a);
    acc(1'b0, a, '0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(1);
    // R1: reset values visible through reads
    tag = "R1"; rd(8'h00); rd(8'h04); rd(8'h18); rd(8'h24); idle(1);
    // R6: control word layout and unused bits
    tag = "R6"; wr(8'h00, 32'hFFFF_FFFF); rd(8'h00); wr(8'h00, 32'h0); rd(8'h00);
    // R2: divide by 1, by 4, by 256
    tag = "R2"; wr(8'h00, 32'h0000_0001); idle(9); rd(8'h04);
    wr(8'h00, 32'h0000_0301); idle(21); rd(8'h04); rd(8'h04);
    wr(8'h00, 32'h0000_FF01); idle(600); rd(8'h04); idle(3); rd(8'h04);
    // R3: run enable clear holds counter and phase
    tag = "R3"; wr(8'h00, 32'h0000_0200); idle(10); rd(8'h04); idle(5); rd(8'h04);
    wr(8'h00, 32'h0000_0201); idle(7); rd(8'h04);
    // R4: debug with and without freeze
    tag = "R4"; wr(8'h00, 32'h0000_0003); dbg_mode = 1'b1; idle(10); rd(8'h04);
    wr(8'h00, 32'h0000_0001); idle(10); rd(8'h04); dbg_mode = 1'b0;
    wr(8'h00, 32'h0000_0003); idle(4); rd(8'h04);
    // R5: counter load, load over step, wrap
    tag = "R5"; wr(8'h04, 32'hFFFF_FFF0); rd(8'h04); idle(30); rd(8'h04);
    wr(8'h04, 32'h1234_5678); wr(8'h04, 32'h0000_0000); rd(8'h04);
    // R7: channel registers
    tag = "R7"; wr(8'h00, 32'h0); wr(8'h04, 32'h0);
    wr(8'h18, 32'd20); wr(8'h28, 32'd7); wr(8'h38, 32'd5); wr(8'h48, 32'd50);
    wr(8'h10, 32'hFFFF_FFFF); wr(8'h30, 32'h1); wr(8'h40, 32'h1);
    rd(8'h10); rd(8'h20); rd(8'h18); rd(8'h28); rd(8'h48);
    // R8: matches at prescale 2, channel 1 disabled never fires
    tag = "R8"; wr(8'h00, 32'h0000_0101); idle(120);
    rd(8'h14); rd(8'h24); rd(8'h34); rd(8'h44);
    // R9: write 0 no effect, write 1 clears, set wins over clear
    tag = "R9"; wr(8'h14, 32'h0); rd(8'h14); wr(8'h14, 32'h1); rd(8'h14);
    wr(8'h00, 32'h0); wr(8'h04, 32'd50); idle(2); wr(8'h44, 32'h1); rd(8'h44);
    wr(8'h48, 32'd999); wr(8'h44, 32'h1); rd(8'h44); wr(8'h34, 32'h1); idle(2);
    // R10: non-word sizes
    tag = "R10"; acc(1'b1, 8'h00, 32'h0000_0001, 2'b00); acc(1'b1, 8'h04, 32'h5, 2'b01);
    acc(1'b0, 8'h04, '0, 2'b11); rd(8'h00); rd(8'h04);
    // R11: reserved and misaligned offsets
    tag = "R11"; wr(8'h08, 32'h1); rd(8'h0C); wr(8'h1C, 32'h1); rd(8'h4C);
    wr(8'h50, 32'h1); rd(8'hF0); wr(8'h02, 32'h1); wr(8'h19, 32'h1); rd(8'h00); rd(8'h18);
    // R12: user-mode accesses
    tag = "R12"; acc(1'b1, 8'h00, 32'h0000_0001, 2'b10, 1'b0);
    acc(1'b1, 8'h28, 32'h77, 2'b10, 1'b0); acc(1'b0, 8'h04, '0, 2'b10, 1'b0);
    rd(8'h00); rd(8'h28);
    // R13: back-to-back mixed requests
    tag = "R13"; wr(8'h00, 32'h1); rd(8'h04); wr(8'h08, 0); rd(8'h04); rd(8'h00); idle(3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule